// File: doc/BRIEF.md
# Byte-Framed Serial Slice Link

This block moves one captured time slice of a front-end readout chip over a single wire. A slice holds 64 hit bits and a 24-bit timestamp. The transmitter cuts the record into eight hit bytes and three timestamp bytes. It wraps each byte in three control bits and shifts the resulting 121-bit frame out at one bit per clock. At a 100 ns clock a whole slice takes 12.1 µs on the wire.

Each 11-bit slot starts with a zero start bit. A kind bit follows, 0 for a hit byte and 1 for a timestamp byte. Then comes an odd-parity bit over the data byte, and last the eight data bits, most significant first. The line rests at logic 1 whenever no frame is being sent. A new record is taken only while the transmitter is idle, so consecutive frames are always separated by at least one idle bit.

A matching receiver on a separate input line waits for a start bit while idle. It then collects 121 bits, reassembles the 88 payload bits and reports a parity error flag and a framing error flag for each of the eleven slots.

Top module: `slice_link_top`

## Requirements
- R1: After reset `tx_line` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: A record is accepted only on a clock edge where `ld_valid` and `tx_ready` are both 1. A `ld_valid` pulse while `tx_ready` is 0 changes neither the frame in flight nor the line after it.
- R3: After an accepted load `tx_ready` is 0 for exactly 121 clock cycles, and `tx_line` carries one frame bit per cycle starting in the cycle right after the accepting edge.
- R4: Every 11-bit slot is sent as: start bit 0, kind bit (0 hit, 1 timestamp), parity bit, then the 8 data bits most significant bit first.
- R5: Slots 0 to 7 carry `ld_hits[63:56]` down to `ld_hits[7:0]`. Slots 8 to 10 carry `ld_stamp[23:16]` down to `ld_stamp[7:0]`.
- R6: The parity bit makes the nine bits formed by the parity bit and the data byte contain an odd number of ones.
- R7: `tx_line` is 1 whenever `tx_ready` is 1.
- R8: The receiver pulses `rx_valid` for one cycle, in the cycle after it samples the 121st frame bit. At that point `rx_hits` and `rx_stamp` hold the reassembled payload, and the outputs hold until the next frame completes.
- R9: `rx_par_err[s]` is 1 exactly when slot s (slot 0 sent first) fails the odd-parity check of R6.
- R10: `rx_frm_err[s]` is 1 exactly when slot s has a start bit of 1 or a kind bit that differs from its position (0 for slots 0-7, 1 for slots 8-10).
- R11: While idle, the receiver starts a frame only on a 0 on `rx_line`. A line held at 1 never produces `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Offer of a record to the transmitter |
| ld_hits | input | 64 | Hit pattern of the offered record |
| ld_stamp | input | 24 | Timestamp of the offered record |
| tx_ready | output | 1 | Transmitter idle, a record may be loaded |
| tx_line | output | 1 | Serial output line, 1 when idle |
| rx_line | input | 1 | Serial input line of the receiver |
| rx_valid | output | 1 | One-cycle pulse when a frame has been received |
| rx_hits | output | 64 | Received hit pattern |
| rx_stamp | output | 24 | Received timestamp |
| rx_par_err | output | 11 | Per-slot parity error flags |
| rx_frm_err | output | 11 | Per-slot start or kind error flags |

## Verification
The bench checks every bit of the line against its own frame builder for all-zero, all-one and random payloads. An all-zero byte shows whether parity is odd or even, and a wrong byte order or bit order shows up as a mismatch at a named bit. It pokes `ld_valid` in mid-frame; a design that reloads while busy would corrupt the frame or send a second one. Corrupted frames are injected into the receiver with a flipped parity bit, start bit, kind bit or data bit. A receiver that mixes up the two error kinds or flags the wrong slot reports a mismatched error vector. A held-high line checks that no frame is started on idle.

// File: rtl/slice_link_pkg.sv
package slice_link_pkg;

    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned HIT_BYTES   = 8;
    localparam int unsigned STAMP_BYTES = 3;
    localparam int unsigned CTRL_W      = 3;

    localparam int unsigned SLOT_W    = BYTE_W + CTRL_W;
    localparam int unsigned SLOTS     = HIT_BYTES + STAMP_BYTES;
    localparam int unsigned FRAME_W   = SLOTS * SLOT_W;
    localparam int unsigned HIT_W     = HIT_BYTES * BYTE_W;
    localparam int unsigned STAMP_W   = STAMP_BYTES * BYTE_W;
    localparam int unsigned PAYLOAD_W = HIT_W + STAMP_W;
    localparam int unsigned CNT_W     = $clog2(FRAME_W + 1);

    // position of the control bits inside a slot, first sent is the MSB
    localparam int unsigned START_POS = SLOT_W - 1;
    localparam int unsigned KIND_POS  = SLOT_W - 2;
    localparam int unsigned PAR_POS   = SLOT_W - 3;

    typedef enum logic {
        KIND_HIT   = 1'b0,
        KIND_STAMP = 1'b1
    } byte_kind_e;

    typedef struct packed {
        logic [HIT_W-1:0]   hits;
        logic [STAMP_W-1:0] stamp;
    } slice_rec_t;

    typedef struct packed {
        slice_rec_t         rec;
        logic [SLOTS-1:0]   par_err;
        logic [SLOTS-1:0]   frm_err;
    } slice_rx_t;

    function automatic byte_kind_e kind_of_slot(int unsigned s);
        return (s >= HIT_BYTES) ? KIND_STAMP : KIND_HIT;
    endfunction

    function automatic logic [SLOT_W-1:0] wrap_byte(logic [BYTE_W-1:0] d, byte_kind_e k);
        // start 0, kind, odd parity over the data byte, data MSB first
        return {1'b0, k, ~^d, d};
    endfunction

    function automatic logic [FRAME_W-1:0] build_frame(slice_rec_t r);
        logic [PAYLOAD_W-1:0] flat;
        logic [FRAME_W-1:0]   f;
        flat = r;
        f    = '0;
        for (int unsigned s = 0; s < SLOTS; s++) begin
            f[FRAME_W-1-s*SLOT_W -: SLOT_W] =
                wrap_byte(flat[PAYLOAD_W-1-s*BYTE_W -: BYTE_W], kind_of_slot(s));
        end
        return f;
    endfunction

    function automatic slice_rx_t decode_frame(logic [FRAME_W-1:0] f);
        slice_rx_t            o;
        logic [PAYLOAD_W-1:0] flat;
        logic [SLOT_W-1:0]    sl;
        flat = '0;
        o    = '0;
        for (int unsigned s = 0; s < SLOTS; s++) begin
            sl = f[FRAME_W-1-s*SLOT_W -: SLOT_W];
            flat[PAYLOAD_W-1-s*BYTE_W -: BYTE_W] = sl[BYTE_W-1:0];
            o.par_err[s] = ~(^{sl[PAR_POS], sl[BYTE_W-1:0]});
            o.frm_err[s] = sl[START_POS] | (sl[KIND_POS] != logic'(kind_of_slot(s)));
        end
        o.rec = flat;
        return o;
    endfunction

endpackage

// File: rtl/slice_serializer.sv
module slice_serializer
    import slice_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               busy,
    output logic               line
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            cnt   <= '0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= frame_in;
            cnt   <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            // refill with ones so the line rests high once the frame is out
            shreg <= {shreg[FRAME_W-2:0], 1'b1};
            cnt   <= cnt + CNT_W'(1);
            if (cnt == LAST_BIT) begin
                busy <= 1'b0;
            end
        end
    end

    assign line = shreg[FRAME_W-1];

endmodule

// File: rtl/slice_deserializer.sv
module slice_deserializer
    import slice_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               line,
    output logic               done,
    output logic [FRAME_W-1:0] frame_out
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-2:0] shreg;
    logic [CNT_W-1:0]   cnt;
    logic               active;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (!active) begin
            if (!line) begin
                shreg  <= {shreg[FRAME_W-3:0], line};
                cnt    <= CNT_W'(1);
                active <= 1'b1;
            end
        end else begin
            shreg <= {shreg[FRAME_W-3:0], line};
            cnt   <= cnt + CNT_W'(1);
            if (cnt == LAST_BIT) begin
                active <= 1'b0;
            end
        end
    end

    assign done      = active && (cnt == LAST_BIT);
    assign frame_out = {shreg, line};

endmodule

// File: rtl/slice_link_top.sv
module slice_link_top
    import slice_link_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_valid,
    input  logic [HIT_W-1:0]   ld_hits,
    input  logic [STAMP_W-1:0] ld_stamp,
    output logic               tx_ready,
    output logic               tx_line,
    input  logic               rx_line,
    output logic               rx_valid,
    output logic [HIT_W-1:0]   rx_hits,
    output logic [STAMP_W-1:0] rx_stamp,
    output logic [SLOTS-1:0]   rx_par_err,
    output logic [SLOTS-1:0]   rx_frm_err
);

    logic               tx_busy;
    logic               accept;
    logic [FRAME_W-1:0] tx_frame;
    slice_rec_t         ld_rec;

    logic               rx_done;
    logic [FRAME_W-1:0] rx_frame;
    slice_rx_t          rx_q;
    logic               rx_valid_q;

    assign ld_rec   = '{hits: ld_hits, stamp: ld_stamp};
    assign tx_frame = build_frame(ld_rec);
    assign accept   = ld_valid && !tx_busy;
    assign tx_ready = !tx_busy;

    slice_serializer ser_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .frame_in (tx_frame),
        .busy     (tx_busy),
        .line     (tx_line)
    );

    slice_deserializer des_i (
        .clk       (clk),
        .rst       (rst),
        .line      (rx_line),
        .done      (rx_done),
        .frame_out (rx_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_q       <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= rx_done;
            if (rx_done) begin
                rx_q <= decode_frame(rx_frame);
            end
        end
    end

    assign rx_valid   = rx_valid_q;
    assign rx_hits    = rx_q.rec.hits;
    assign rx_stamp   = rx_q.rec.stamp;
    assign rx_par_err = rx_q.par_err;
    assign rx_frm_err = rx_q.frm_err;

endmodule

// File: rtl/slice_link_chk.sv
module slice_link_chk
    import slice_link_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic ld_valid,
    input logic tx_ready,
    input logic tx_line,
    input logic rx_valid
);

    logic [CNT_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || tx_ready) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + CNT_W'(1);
        end
    end

    assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> tx_line);

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && ld_valid) |=> !tx_ready);

    assert_busy_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_ready) |-> $past(ld_valid));

    assert_start_bit_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_ready) |-> !tx_line);

    assert_frame_len_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_ready) |-> (run_len == CNT_W'(FRAME_W)));

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

bind slice_link_top slice_link_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .tx_ready (tx_ready),
    .tx_line  (tx_line),
    .rx_valid (rx_valid)
);

// File: tb/slice_link_tb_top.sv
module slice_link_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_valid = 1'b0;
    logic [63:0] ld_hits = '0;
    logic [23:0] ld_stamp = '0;
    logic        tx_ready, tx_line;
    logic        rx_line;
    logic        rx_valid;
    logic [63:0] rx_hits;
    logic [23:0] rx_stamp;
    logic [10:0] rx_par_err, rx_frm_err;

    logic inj_en  = 1'b0;
    logic inj_bit = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    assign rx_line = inj_en ? inj_bit : tx_line;

    slice_link_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .ld_valid   (ld_valid),
        .ld_hits    (ld_hits),
        .ld_stamp   (ld_stamp),
        .tx_ready   (tx_ready),
        .tx_line    (tx_line),
        .rx_line    (rx_line),
        .rx_valid   (rx_valid),
        .rx_hits    (rx_hits),
        .rx_stamp   (rx_stamp),
        .rx_par_err (rx_par_err),
        .rx_frm_err (rx_frm_err)
    );

    // expected line bits, index 120 goes out first
    function automatic logic [120:0] exp_frame(logic [63:0] h, logic [23:0] t);
        logic [120:0] f;
        logic [7:0]   b;
        int           p;
        int           ones;
        f = '1;
        p = 120;
        for (int k = 0; k < 11; k++) begin
            if (k < 8) b = h[63-8*k -: 8];
            else       b = t[23-8*(k-8) -: 8];
            ones = 0;
            for (int j = 0; j < 8; j++) ones += int'(b[j]);
            f[p]   = 1'b0;
            f[p-1] = (k >= 8);
            f[p-2] = ((ones % 2) == 0);
            p -= 3;
            for (int j = 7; j >= 0; j--) begin
                f[p] = b[j];
                p--;
            end
        end
        return f;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // load a record, follow the line bit by bit, then check the looped-back receive
    task automatic send_check(input logic [63:0] h, input logic [23:0] t, input bit poke);
        logic [120:0] ef;
        int           bad_bits;
        int           bad_ready;
        ef = exp_frame(h, t);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_hits  = h;
        ld_stamp = t;
        @(negedge clk);
        ld_valid = 1'b0;
        bad_bits  = 0;
        bad_ready = 0;
        for (int i = 0; i < 121; i++) begin
            if (tx_line !== ef[120-i]) bad_bits++;
            if (tx_ready !== 1'b0) bad_ready++;
            if (poke && i == 50) begin
                ld_valid = 1'b1;
                ld_hits  = ~h;
                ld_stamp = ~t;
            end
            @(negedge clk);
            if (poke && i == 50) ld_valid = 1'b0;
        end
        check(bad_bits == 0, "R4 R5 R6 line bits", 128'(bad_bits), 128'(0));
        check(bad_ready == 0, "R3 busy cycles", 128'(bad_ready), 128'(0));
        check(tx_ready === 1'b1 && tx_line === 1'b1, "R3 R7 idle after frame",
              128'({tx_ready, tx_line}), 128'(2'b11));
        check(rx_valid === 1'b1, "R8 valid timing", 128'(rx_valid), 128'(1));
        check(rx_hits === h && rx_stamp === t, "R8 payload",
              128'({rx_hits, rx_stamp}), 128'({h, t}));
        check(rx_par_err === '0 && rx_frm_err === '0, "R9 R10 clean frame",
              128'({rx_par_err, rx_frm_err}), 128'(0));
        if (poke) begin
            repeat (3) @(negedge clk);
            check(tx_ready === 1'b1 && tx_line === 1'b1, "R2 no reload from busy poke",
                  128'({tx_ready, tx_line}), 128'(2'b11));
        end
    endtask

    task automatic inject_check(input logic [120:0] f, input logic [63:0] eh,
                                input logic [23:0] et, input logic [10:0] epar,
                                input logic [10:0] efrm, input string tag);
        @(negedge clk);
        inj_en  = 1'b1;
        inj_bit = f[120];
        for (int i = 1; i < 121; i++) begin
            @(negedge clk);
            inj_bit = f[120-i];
        end
        @(negedge clk);
        inj_bit = 1'b1;
        check(rx_valid === 1'b1, {tag, " R8 valid"}, 128'(rx_valid), 128'(1));
        check(rx_par_err === epar, {tag, " R9 parity flags"}, 128'(rx_par_err), 128'(epar));
        check(rx_frm_err === efrm, {tag, " R10 framing flags"}, 128'(rx_frm_err), 128'(efrm));
        check(rx_hits === eh && rx_stamp === et, {tag, " R8 payload"},
              128'({rx_hits, rx_stamp}), 128'({eh, et}));
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0]  h;
        logic [23:0]  t;
        logic [120:0] f;
        int unsigned  seed;
        int           seen;
        seed = $urandom(32'd20240611);

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(tx_line === 1'b1, "R1 line idle", 128'(tx_line), 128'(1));
        check(tx_ready === 1'b1, "R1 ready", 128'(tx_ready), 128'(1));
        check(rx_valid === 1'b0, "R1 no valid", 128'(rx_valid), 128'(0));

        // directed corner payloads (R4 R5 R6)
        send_check(64'h0, 24'h0, 1'b0);
        send_check('1, '1, 1'b0);
        send_check(64'h0123_4567_89AB_CDEF, 24'hA5_0F_81, 1'b0);
        // R2 load offered while busy is ignored
        send_check(64'h8000_0000_0000_0001, 24'h80_0001, 1'b1);

        // constrained random payloads, back to back (R7 one idle bit)
        for (int n = 0; n < 8; n++) begin
            h = {$urandom(), $urandom()};
            t = 24'($urandom());
            if (n == 2) h[63:56] = 8'h00;
            if (n == 5) t[7:0]   = 8'hFF;
            send_check(h, t, 1'b0);
        end

        // receiver error detection on injected frames
        h = 64'hDEAD_BEEF_0BAD_F00D;
        t = 24'h12_34_56;
        f = exp_frame(h, t);
        f[120-33-2] = ~f[120-33-2];        // parity bit of slot 3
        inject_check(f, h, t, 11'h008, 11'h000, "parity flip slot3");
        f = exp_frame(h, t);
        f[120-55] = ~f[120-55];            // start bit of slot 5
        inject_check(f, h, t, 11'h000, 11'h020, "start flip slot5");
        f = exp_frame(h, t);
        f[120-99-1] = ~f[120-99-1];        // kind bit of slot 9
        inject_check(f, h, t, 11'h000, 11'h200, "kind flip slot9");
        f = exp_frame(h, t);
        f[120-88-3] = ~f[120-88-3];        // data MSB of slot 8, stamp bit 23
        inject_check(f, h, t ^ 24'h80_0000, 11'h100, 11'h000, "data flip slot8");

        // R11 a line held high never starts a frame
        inj_en  = 1'b1;
        inj_bit = 1'b1;
        seen    = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (rx_valid === 1'b1) seen++;
        end
        inj_en = 1'b0;
        check(seen == 0, "R11 idle line no frame", 128'(seen), 128'(0));

        // receiver still works after idle stretch
        send_check(64'hFFFF_0000_FFFF_0000, 24'h00_FF_00, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule